// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial front end of a byte-addressed memory. It is an SPI slave that works in clock modes 0 and 3. It runs in a faster system clock, which oversamples the chip select, serial clock, data-in and hold pins. Each frame starts with an 8-bit command code. For an array access a 16-bit address follows. After that the block either streams array bytes out on the data-out pin or hands each received byte to an external page buffer, together with its array address.

Status reads return a status byte that the surrounding logic supplies. Status writes, write-enable changes and write commits leave the block as single-cycle pulses. The storage array, the page buffer, the protection policy and the internal write timer all live outside the block. The data-out pin is a value plus an output enable. The enable is low whenever the pin must float. Unknown codes, and every code except a status read while the busy input is high, silence the rest of the frame.

Top module: `spi_mem_cmd`

## Requirements
- R1: After reset, and in every system clock cycle that follows a detected chip-select rise, `spi_miso_oe` is 0. While chip select is high the block issues no pulse apart from the end-of-frame pulses of R7, R8 and R10.
- R2: Only six command codes are recognised: 0x06 sets the write enable, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array. Any other first byte leaves `spi_miso_oe` low and issues no pulse until chip select rises.
- R3: Data-in is sampled on rising SCK and data-out changes on falling SCK, most significant bit first. This holds whether SCK idles low (mode 0) or high (mode 3).
- R4: An array read takes a 16-bit address, most significant byte first, of which only the low ADDR_BITS bits count. The block then streams the bytes at consecutive addresses, wrapping from the top address to 0, until chip select rises.
- R5: A status read drives `status_i` out from the first falling SCK after the code. It samples `status_i` again for every further byte, and it is accepted while `busy_i` is high.
- R6: While `busy_i` is high at the end of the code byte, every code other than 0x05 is ignored for the rest of the frame.
- R7: Code 0x06 (or 0x04) gives one `wel_set_o` (or `wel_clr_o`) pulse when chip select rises, but only if no rising SCK followed the code byte.
- R8: In an array write, each complete data byte is presented for one cycle on `wr_byte_valid_o`, together with its address. Only the low PAGE_BITS address bits advance, wrapping within the page. If at least one byte arrived, `wr_commit_o` pulses once at the chip-select rise.
- R9: If chip select rises partway through a byte, the partial byte is dropped with no effect. A commit that earlier complete bytes made pending is still issued.
- R10: In a status write, the first data byte appears on `sr_data_o`, and `sr_commit_o` pulses once at the chip-select rise. Later bytes are ignored.
- R11: A hold pause starts when hold falls while SCK is low and ends when hold rises while SCK is low. During the pause `spi_miso_oe` is 0 and SCK and data-in activity has no effect. The transfer then resumes exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_csn | input | 1 | Chip select pin, active low |
| spi_mosi | input | 1 | Serial data-in pin |
| spi_hold_n | input | 1 | Hold pin, active low |
| spi_miso | output | 1 | Serial data-out value |
| spi_miso_oe | output | 1 | Data-out drive enable, 0 means high impedance |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte returned by status reads |
| rd_addr_o | output | ADDR_BITS | Array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o, combinational |
| wr_byte_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | ADDR_BITS | Address of the strobed write byte |
| wr_byte_o | output | 8 | Strobed write byte |
| wr_commit_o | output | 1 | Start the internal array write |
| sr_data_o | output | 8 | Byte received by a status write |
| sr_commit_o | output | 1 | Apply sr_data_o to the status register |
| wel_set_o | output | 1 | Set the write-enable latch |
| wel_clr_o | output | 1 | Clear the write-enable latch |

## Verification
The bench builds the block with ADDR_BITS of 8 and PAGE_BITS of 2. With these values, an address of 0x00FF reaches the top-of-array wrap within three bytes. An address of 0xAB20 shows that the high address byte is dropped. A five-byte write crosses the four-byte page boundary. The array model is a formula of the address, so every expected read byte follows from R4 alone. The vector table alternates modes 0 and 3.

// File: rtl/spi_mem_pkg.sv
// Shared command codes and frame phases of the serial memory command engine.
package spi_mem_pkg;
    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_ARR_RD  = 8'h03;
    localparam logic [7:0] OP_ARR_WR  = 8'h02;

    typedef enum logic [2:0] {
        PH_CODE, PH_ADDR, PH_RDATA, PH_STAT, PH_WDATA, PH_SRIN, PH_ENDWAIT, PH_MUTE
    } phase_t;
endpackage

// File: rtl/spi_in_sync.sv
// Two-flop synchroniser bank for asynchronous pins.
// Assumes: pins are slower than clk by at least 4x. The lowest EDGE_W bits
// also get a change flag (current synced level differs from the previous one).
module spi_in_sync #(
    parameter int W      = 4,
    parameter int EDGE_W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      lvl_o,
    output logic [EDGE_W-1:0] chg_o
);
    logic [W-1:0] meta_q, sync_q;
    logic [EDGE_W-1:0] prev_q;

    // two-stage capture of every pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    generate
        for (genvar g = 0; g < EDGE_W; g++) begin : g_edge
            // previous synced level for change detection
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q[g] <= RST_VAL[g];
                else        prev_q[g] <= sync_q[g];
            end
            assign chg_o[g] = sync_q[g] ^ prev_q[g];
        end
    endgenerate

    assign lvl_o = sync_q;
endmodule

// File: rtl/spi_tx_shift.sv
// Output shifter: on each step it drives the next bit, MSB first; at a byte
// boundary it reloads from din_i and flags the load so the caller can advance.
// Assumes: clear_i is high whenever the frame is not selected.
module spi_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic              bit_o,
    output logic              load_o
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-2:0] sh_q;
    logic [CW-1:0]     left_q;

    assign load_o = step_i && (left_q == '0);

    // shift or reload on each falling-clock step
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sh_q   <= '0;
            left_q <= '0;
            bit_o  <= 1'b0;
        end else if (load_o) begin
            bit_o  <= din_i[BYTE_W-1];
            sh_q   <= din_i[BYTE_W-2:0];
            left_q <= CW'(BYTE_W - 1);
        end else if (step_i) begin
            bit_o  <= sh_q[BYTE_W-2];
            sh_q   <= {sh_q[BYTE_W-3:0], 1'b0};
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/spi_mem_cmd.sv
// SPI slave command engine for a byte-addressed serial memory (modes 0 and 3).
// Assumes: clk runs at least 4x faster than SCK; rd_data_i follows rd_addr_o
// combinationally; busy_i and status_i come from the external write controller.
module spi_mem_cmd #(
    parameter int ADDR_BITS = 12,
    parameter int PAGE_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_csn,
    input  logic                 spi_mosi,
    input  logic                 spi_hold_n,
    output logic                 spi_miso,
    output logic                 spi_miso_oe,
    input  logic                 busy_i,
    input  logic [7:0]           status_i,
    output logic [ADDR_BITS-1:0] rd_addr_o,
    input  logic [7:0]           rd_data_i,
    output logic                 wr_byte_valid_o,
    output logic [ADDR_BITS-1:0] wr_addr_o,
    output logic [7:0]           wr_byte_o,
    output logic                 wr_commit_o,
    output logic [7:0]           sr_data_o,
    output logic                 sr_commit_o,
    output logic                 wel_set_o,
    output logic                 wel_clr_o
);
    import spi_mem_pkg::*;

    localparam int AW = ADDR_BITS;
    localparam int PB = PAGE_BITS;

    // pin order: 0 sck, 1 csn, 2 hold_n, 3 mosi
    logic [3:0] lvl;
    logic [2:0] chg;

    spi_in_sync #(.W(4), .EDGE_W(3), .RST_VAL(4'b0110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({spi_mosi, spi_hold_n, spi_csn, spi_sck}),
        .lvl_o (lvl),
        .chg_o (chg)
    );

    logic sck_l, cs_l, si_l, cs_rise, hold_rise, hold_fall;
    assign sck_l     = lvl[0];
    assign cs_l      = lvl[1];
    assign si_l      = lvl[3];
    assign cs_rise   = chg[1] && lvl[1];
    assign hold_rise = chg[2] && lvl[2];
    assign hold_fall = chg[2] && !lvl[2];

    logic pause_q, pause_n;

    // next hold-pause state: hold edges count only while SCK is low
    always_comb begin
        pause_n = pause_q;
        if (cs_l)                        pause_n = 1'b0;
        else if (hold_fall && !sck_l)    pause_n = 1'b1;
        else if (hold_rise && !sck_l)    pause_n = 1'b0;
    end

    // hold-pause register
    always_ff @(posedge clk) begin
        if (!rst_n) pause_q <= 1'b0;
        else        pause_q <= pause_n;
    end

    logic sck_up, sck_dn;
    assign sck_up = chg[0] && sck_l  && !cs_l && !pause_q;
    assign sck_dn = chg[0] && !sck_l && !cs_l && !pause_q;

    phase_t         phase_q;
    logic [6:0]     rx_q;
    logic [2:0]     bit_q;
    logic [7:0]     addr_hi_q;
    logic           addr_cnt_q, is_read_q, is_set_q;
    logic [AW-1:0]  rd_ptr_q, wr_ptr_q;
    logic           wr_pend_q, sr_pend_q, tx_started_q;
    logic           byte_done;
    logic [7:0]     byte_val;

    assign byte_done = sck_up && (bit_q == 3'd7);
    assign byte_val  = {rx_q, si_l};

    logic tx_step, tx_load, tx_bit;
    assign tx_step = sck_dn && (phase_q == PH_RDATA || phase_q == PH_STAT);

    spi_tx_shift #(.BYTE_W(8)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cs_l),
        .step_i  (tx_step),
        .din_i   ((phase_q == PH_RDATA) ? rd_data_i : status_i),
        .bit_o   (tx_bit),
        .load_o  (tx_load)
    );

    // frame sequencer: code decode, address gathering, byte hand-off, end-of-frame pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CODE;   rx_q <= '0;        bit_q <= '0;
            addr_hi_q <= '0;      addr_cnt_q <= 1'b0; is_read_q <= 1'b0;
            is_set_q <= 1'b0;     rd_ptr_q <= '0;    wr_ptr_q <= '0;
            wr_pend_q <= 1'b0;    sr_pend_q <= 1'b0; tx_started_q <= 1'b0;
            wr_byte_valid_o <= 1'b0; wr_addr_o <= '0; wr_byte_o <= '0;
            wr_commit_o <= 1'b0;  sr_data_o <= '0;   sr_commit_o <= 1'b0;
            wel_set_o <= 1'b0;    wel_clr_o <= 1'b0; spi_miso_oe <= 1'b0;
        end else begin
            wr_byte_valid_o <= 1'b0;
            wr_commit_o     <= 1'b0;
            sr_commit_o     <= 1'b0;
            wel_set_o       <= 1'b0;
            wel_clr_o       <= 1'b0;
            if (cs_l) begin
                if (cs_rise) begin
                    wel_set_o   <= (phase_q == PH_ENDWAIT) && is_set_q;
                    wel_clr_o   <= (phase_q == PH_ENDWAIT) && !is_set_q;
                    wr_commit_o <= wr_pend_q;
                    sr_commit_o <= sr_pend_q;
                end
                phase_q <= PH_CODE;  bit_q <= '0;  addr_cnt_q <= 1'b0;
                wr_pend_q <= 1'b0;   sr_pend_q <= 1'b0;
                tx_started_q <= 1'b0; spi_miso_oe <= 1'b0;
            end else begin
                if (sck_up) begin
                    rx_q  <= byte_val[6:0];
                    bit_q <= bit_q + 3'd1;
                    if (phase_q == PH_ENDWAIT) phase_q <= PH_MUTE;
                end
                if (byte_done) begin
                    case (phase_q)
                        PH_CODE: begin
                            if (busy_i && byte_val != OP_STAT_RD) phase_q <= PH_MUTE;
                            else begin
                                case (byte_val)
                                    OP_WR_EN:   begin phase_q <= PH_ENDWAIT; is_set_q <= 1'b1; end
                                    OP_WR_DIS:  begin phase_q <= PH_ENDWAIT; is_set_q <= 1'b0; end
                                    OP_STAT_RD: phase_q <= PH_STAT;
                                    OP_STAT_WR: phase_q <= PH_SRIN;
                                    OP_ARR_RD:  begin phase_q <= PH_ADDR; is_read_q <= 1'b1; end
                                    OP_ARR_WR:  begin phase_q <= PH_ADDR; is_read_q <= 1'b0; end
                                    default:    phase_q <= PH_MUTE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (!addr_cnt_q) begin
                                addr_hi_q  <= byte_val;
                                addr_cnt_q <= 1'b1;
                            end else if (is_read_q) begin
                                rd_ptr_q <= AW'({addr_hi_q, byte_val});
                                phase_q  <= PH_RDATA;
                            end else begin
                                wr_ptr_q <= AW'({addr_hi_q, byte_val});
                                phase_q  <= PH_WDATA;
                            end
                        end
                        PH_WDATA: begin
                            wr_byte_valid_o <= 1'b1;
                            wr_byte_o       <= byte_val;
                            wr_addr_o       <= wr_ptr_q;
                            wr_ptr_q        <= {wr_ptr_q[AW-1:PB], wr_ptr_q[PB-1:0] + PB'(1)};
                            wr_pend_q       <= 1'b1;
                        end
                        PH_SRIN: begin
                            sr_data_o <= byte_val;
                            sr_pend_q <= 1'b1;
                            phase_q   <= PH_MUTE;
                        end
                        default: ;
                    endcase
                end
                if (tx_load) begin
                    tx_started_q <= 1'b1;
                    if (phase_q == PH_RDATA) rd_ptr_q <= rd_ptr_q + AW'(1);
                end
                spi_miso_oe <= !pause_n && (tx_started_q || tx_load);
            end
        end
    end

    assign rd_addr_o = rd_ptr_q;
    assign spi_miso  = tx_bit;

    // R1
    oe_off_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !spi_miso_oe);
    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_q |-> !spi_miso_oe);
    // R7
    wel_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set_o || wel_clr_o) |-> $past(cs_rise));
    // R8
    commit_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(cs_rise));
    // R10
    sr_commit_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_commit_o |-> $past(cs_rise));
    // R8
    wr_byte_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_valid_o |-> !$past(cs_l));
endmodule

// File: tb/tb_spi_mem_cmd.sv
// Self-checking bench for spi_mem_cmd, built with ADDR_BITS=8 and PAGE_BITS=2.
module tb_spi_mem_cmd;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_oe, busy = 1'b0;
    logic [7:0] stat = 8'h00;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_byte, sr_data;
    logic wr_valid, wr_commit, sr_commit, wel_set, wel_clr;

    always #4 clk = ~clk;

    // model array: byte value is a formula of its address
    assign rd_data = rd_addr ^ 8'h5A;

    spi_mem_cmd #(.ADDR_BITS(AW), .PAGE_BITS(2)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .busy_i(busy),
        .status_i(stat), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_byte_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_byte_o(wr_byte),
        .wr_commit_o(wr_commit), .sr_data_o(sr_data), .sr_commit_o(sr_commit),
        .wel_set_o(wel_set), .wel_clr_o(wel_clr)
    );

    int total = 0, bad = 0;
    int n_set = 0, n_clr = 0, n_com = 0, n_src = 0, n_wrb = 0, n_oe = 0;
    logic [7:0] log_a [16];
    logic [7:0] log_d [16];
    logic mode3 = 1'b0;
    bit done = 1'b0;

    // event counters and write-byte log taken from the ports
    always @(posedge clk) begin
        if (wel_set)   n_set++;
        if (wel_clr)   n_clr++;
        if (wr_commit) n_com++;
        if (sr_commit) n_src++;
        if (miso_oe)   n_oe++;
        if (wr_valid) begin
            log_a[n_wrb % 16] = wr_addr;
            log_d[n_wrb % 16] = wr_byte;
            n_wrb++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic sel(input logic m3);
        mode3 = m3;
        sck = m3;
        half();
        csn = 1'b0;
        half();
    endtask

    task automatic desel();
        half();
        csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // send the top n bits of tx, collecting the bits seen on data-out
    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            half();
            rx[i] = miso;
            sck = 1'b1;
            half();
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    // read vectors: {mode3, address, expected first byte}
    localparam logic [24:0] RD_VEC [4] = '{
        {1'b0, 16'h0010, 8'h4A},
        {1'b1, 16'hAB20, 8'h7A},
        {1'b0, 16'h00FF, 8'hA5},
        {1'b1, 16'h1234, 8'h6E}
    };

    initial begin
        logic [7:0] r;
        int b0, oe0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
        chk(n_set + n_clr + n_com + n_src + n_wrb == 0, "R1 no pulses after reset",
            n_set + n_clr + n_com + n_src + n_wrb, 0);

        // R3 R4 vector table: both modes, high address bits dropped, top wrap
        for (int v = 0; v < 4; v++) begin
            logic [7:0] a;
            sel(RD_VEC[v][24]);
            xb(8'h03, r);
            xb(RD_VEC[v][23:16], r);
            xb(RD_VEC[v][15:8], r);
            a = RD_VEC[v][15:8];
            xb(8'h00, r);
            chk(r == RD_VEC[v][7:0], "R3 R4 first read byte", r, RD_VEC[v][7:0]);
            for (int k = 1; k < 3; k++) begin
                logic [7:0] e;
                e = (a + 8'(k)) ^ 8'h5A;
                xb(8'h00, r);
                chk(r == e, "R4 sequential read byte", r, e);
            end
            desel();
            chk(miso_oe == 1'b0, "R1 oe low after deselect", miso_oe, 0);
        end

        // R5 R6 status read while busy, status sampled per byte
        busy = 1'b1;
        stat = 8'h8D;
        sel(1'b0);
        xb(8'h05, r);
        xb(8'h00, r);
        chk(r == 8'h8D, "R5 status byte while busy", r, 8'h8D);
        stat = 8'h8C;
        xb(8'h00, r);
        chk(r == 8'h8C, "R5 status byte resampled", r, 8'h8C);
        desel();

        // R6 busy blocks write enable and array read
        b0 = n_set; oe0 = n_oe;
        sel(1'b0); xb(8'h06, r); desel();
        chk(n_set == b0, "R6 enable ignored while busy", n_set - b0, 0);
        sel(1'b0); xb(8'h03, r); xb(8'h00, r); xb(8'h10, r); xb(8'h00, r); desel();
        chk(n_oe == oe0, "R6 read ignored while busy", n_oe - oe0, 0);
        busy = 1'b0;

        // R7 enable latch only with exactly eight clocks
        b0 = n_set;
        sel(1'b1); xb(8'h06, r); desel();
        chk(n_set == b0 + 1, "R7 enable pulse", n_set - b0, 1);
        b0 = n_set;
        sel(1'b0); xb(8'h06, r); xbits(8'h80, 1, r); desel();
        chk(n_set == b0, "R7 enable dropped after extra clock", n_set - b0, 0);
        b0 = n_clr;
        sel(1'b0); xb(8'h04, r); desel();
        chk(n_clr == b0 + 1, "R7 disable pulse", n_clr - b0, 1);

        // R2 unknown code stays silent
        b0 = n_set + n_clr + n_com + n_src + n_wrb; oe0 = n_oe;
        sel(1'b0); xb(8'hFF, r); xb(8'h03, r); xb(8'h06, r); desel();
        chk(n_oe == oe0, "R2 unknown code output stays off", n_oe - oe0, 0);
        chk(n_set + n_clr + n_com + n_src + n_wrb == b0, "R2 unknown code no pulse",
            n_set + n_clr + n_com + n_src + n_wrb - b0, 0);

        // R8 page write wrapping inside a four-byte page
        b0 = n_wrb; oe0 = n_com;
        sel(1'b0);
        xb(8'h02, r); xb(8'h00, r); xb(8'h16, r);
        for (int k = 0; k < 5; k++) xb(8'hA0 + 8'(k), r);
        desel();
        chk(n_wrb == b0 + 5, "R8 write byte count", n_wrb - b0, 5);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] ea;
            ea = {6'b000101, 2'(2 + k)};
            chk(log_a[(b0 + k) % 16] == ea, "R8 write address page wrap", log_a[(b0 + k) % 16], ea);
            chk(log_d[(b0 + k) % 16] == 8'hA0 + 8'(k), "R8 write byte", log_d[(b0 + k) % 16], 8'hA0 + 8'(k));
        end
        chk(n_com == oe0 + 1, "R8 commit pulse", n_com - oe0, 1);

        // R9 partial byte dropped, pending commit still issued
        b0 = n_wrb; oe0 = n_com;
        sel(1'b1);
        xb(8'h02, r); xb(8'h00, r); xb(8'h30, r); xb(8'h77, r); xbits(8'hFF, 3, r);
        desel();
        chk(n_wrb == b0 + 1, "R9 only complete byte passed", n_wrb - b0, 1);
        chk(n_com == oe0 + 1, "R9 pending commit issued", n_com - oe0, 1);
        b0 = n_wrb; oe0 = n_com;
        sel(1'b0);
        xb(8'h02, r); xb(8'h00, r); xb(8'h30, r); xbits(8'hFF, 5, r);
        desel();
        chk(n_wrb == b0 && n_com == oe0, "R9 partial-only write has no effect",
            n_wrb - b0 + n_com - oe0, 0);

        // R10 status write keeps the first byte
        b0 = n_src;
        sel(1'b0); xb(8'h01, r); xb(8'h8C, r); xb(8'h11, r); desel();
        chk(n_src == b0 + 1, "R10 status commit pulse", n_src - b0, 1);
        chk(sr_data == 8'h8C, "R10 status byte", sr_data, 8'h8C);

        // R11 hold pause mid-read
        sel(1'b0);
        xb(8'h03, r); xb(8'h00, r); xb(8'h40, r);
        half();
        hold_n = 1'b0;
        half();
        chk(miso_oe == 1'b0, "R11 output off in pause", miso_oe, 0);
        for (int k = 0; k < 3; k++) begin
            mosi = ~mosi; sck = 1'b1; half(); sck = 1'b0; half();
        end
        hold_n = 1'b1;
        half();
        chk(miso_oe == 1'b1, "R11 output back after pause", miso_oe, 1);
        xb(8'h00, r);
        chk(r == 8'h1A, "R11 byte intact over pause", r, 8'h1A);
        xb(8'h00, r);
        chk(r == 8'h1B, "R11 next byte after pause", r, 8'h1B);
        desel();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule